// File: doc/BRIEF.md
# Timer output compare channel

This block is one channel of a general-purpose timer, used in output mode. Each timer clock, it compares the running counter value, supplied from outside, against an active compare value. From the result and a 3-bit compare mode, it produces a registered reference level. That level feeds the later output stages (polarity and pin logic), which live outside this block.

The compare value is written through a write strobe. When preloading is enabled, the write goes to a holding copy, and the active value takes it on the next update event. Otherwise the write takes effect at once.

The two PWM modes follow the counting direction. They move the reference only when the comparison outcome changes, or when the channel arrives from timing mode. A fast path lets a trigger edge stand in for a compare match in the PWM modes. A 2-bit channel-role field picks output or one of three input roles. That field is frozen while the channel is enabled.

Top module: `oc_channel`

## Requirements
- R1: During and after synchronous reset, `oc_ref` is 0, `cmp_active` is 0 and `io_sel` is 00.
- R2: A "match" means `cnt_val == cmp_active`. With `oc_mode` 000 the reference holds. With 001 a match sets it to 1. With 010 a match clears it to 0. Without a match it holds.
- R3: With `oc_mode` 011, each cycle with a match inverts the reference.
- R4: `oc_mode` 100 forces the reference to 0, and 101 forces it to 1, whatever the counter.
- R5: In PWM mode 0 (`oc_mode` 110), the PWM level depends on direction. Counting up (`cnt_down`=0), it is 1 when `cnt_val < cmp_active` and 0 otherwise. Counting down, it is 0 when `cnt_val > cmp_active` and 1 otherwise.
- R6: PWM mode 1 (`oc_mode` 111) gives the inverse of the R5 level in both directions.
- R7: In a PWM mode, the reference takes the PWM level only in two cases: the mode in the previous cycle was 000, or the raw comparison outcome (the R5 level) differs from the previous cycle's. Otherwise it holds.
- R8: When `fast_en`=1, a PWM mode is selected and `trig_edge`=1, the reference goes to the compare level. That level is 0 for mode 110 counting up, 1 for 110 counting down, 1 for 111 counting up and 0 for 111 counting down. It then holds until R7 moves it.
- R9: With `shadow_en`=1, a write changes only the holding copy. `cmp_active` loads the holding copy, as it stood before that cycle's write, one cycle after `upd_evt`.
- R10: With `shadow_en`=0, a write appears on `cmp_active` one cycle later, and `upd_evt` has no effect.
- R11: A `sel_wr` write to `io_sel` (00 output, 01/10/11 input roles) is ignored while `ch_en`=1. While `io_sel` is not 00, the reference holds.
- R12: The reference is registered. It reflects the inputs of one clock edge after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | CNT_W | Current counter value |
| cnt_down | input | 1 | 1 when the counter counts down |
| upd_evt | input | 1 | Update event pulse |
| trig_edge | input | 1 | Active trigger-input edge pulse |
| ch_en | input | 1 | Channel enable |
| oc_mode | input | 3 | Compare mode |
| shadow_en | input | 1 | Compare value preload enable |
| fast_en | input | 1 | Fast trigger response enable |
| cmp_wr | input | 1 | Compare value write strobe |
| cmp_wdata | input | CNT_W | Compare value write data |
| sel_wr | input | 1 | Channel role write strobe |
| sel_wdata | input | 2 | Channel role write data |
| oc_ref | output | 1 | Registered reference level |
| cmp_active | output | CNT_W | Active compare value |
| io_sel | output | 2 | Current channel role |

## Verification
Every result here is due exactly one timer clock after the edge that samples its cause. This holds for the reference level, the active compare value after a direct write or an update event, and the channel role after a write. A compare write followed at once by a matching count therefore affects the reference two edges later.

The bench changes inputs only just after a falling edge. It steps a behavioural model once per rising edge and compares all three outputs at the following falling edge. This keeps every comparison aligned to that one-edge latency.

// File: rtl/oc_pkg.sv
package oc_pkg;

    typedef enum logic [2:0] {
        OCM_TIMING = 3'b000,
        OCM_SET    = 3'b001,
        OCM_CLR    = 3'b010,
        OCM_TOG    = 3'b011,
        OCM_LOW    = 3'b100,
        OCM_HIGH   = 3'b101,
        OCM_PWM0   = 3'b110,
        OCM_PWM1   = 3'b111
    } oc_mode_e;

    typedef enum logic [1:0] {
        IOS_OUT    = 2'b00,
        IOS_IN_A   = 2'b01,
        IOS_IN_B   = 2'b10,
        IOS_IN_TRG = 2'b11
    } io_sel_e;

    typedef struct packed {
        logic match;
        logic raw;
    } cmp_res_t;

    function automatic logic is_pwm(input oc_mode_e m);
        return (m == OCM_PWM0) || (m == OCM_PWM1);
    endfunction

    // level a PWM mode reaches when the counter meets the compare value
    function automatic logic pwm_cmp_level(input oc_mode_e m, input logic down);
        return (m == OCM_PWM1) ^ down;
    endfunction

endpackage

// File: rtl/oc_cmp_store.sv
module oc_cmp_store
    import oc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shadow_en,
    input  logic             upd_evt,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] active
);
    logic [CNT_W-1:0] hold_q;
    logic [CNT_W-1:0] act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            act_q  <= '0;
        end else begin
            if (wr) hold_q <= wdata;
            if (wr && !shadow_en)
                act_q <= wdata;
            else if (shadow_en && upd_evt)
                act_q <= hold_q;
        end
    end

    assign active = act_q;

    a_r10_direct_write: assert property (@(posedge clk) disable iff (rst)
        (wr && !shadow_en) |=> (active == $past(wdata)));
    a_r9_preload_holds: assert property (@(posedge clk) disable iff (rst)
        (shadow_en && !upd_evt) |=> $stable(active));

endmodule

// File: rtl/oc_sel_lock.sv
module oc_sel_lock
    import oc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    ch_en,
    input  logic    wr,
    input  io_sel_e wdata,
    output io_sel_e sel
);
    io_sel_e sel_q;

    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= IOS_OUT;
        else if (wr && !ch_en)
            sel_q <= wdata;
    end

    assign sel = sel_q;

    a_r11_locked: assert property (@(posedge clk) disable iff (rst)
        ch_en |=> $stable(sel));

endmodule

// File: rtl/oc_ref_gen.sv
module oc_ref_gen
    import oc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_down,
    input  logic [CNT_W-1:0] cmp_val,
    input  oc_mode_e         mode,
    input  logic             out_mode,
    input  logic             fast_en,
    input  logic             trig_edge,
    output logic             ref_o
);
    cmp_res_t res;
    logic     ref_q, ref_d;
    logic     raw_q;
    oc_mode_e mode_q;
    logic     pwm_lvl;

    always_comb begin
        res.match = (cnt_val == cmp_val);
        res.raw   = cnt_down ? (cnt_val <= cmp_val) : (cnt_val < cmp_val);
    end

    assign pwm_lvl = res.raw ^ (mode == OCM_PWM1);

    always_comb begin
        ref_d = ref_q;
        if (out_mode) begin
            unique case (mode)
                OCM_TIMING: ref_d = ref_q;
                OCM_SET:    if (res.match) ref_d = 1'b1;
                OCM_CLR:    if (res.match) ref_d = 1'b0;
                OCM_TOG:    if (res.match) ref_d = !ref_q;
                OCM_LOW:    ref_d = 1'b0;
                OCM_HIGH:   ref_d = 1'b1;
                default: begin
                    if (fast_en && trig_edge)
                        ref_d = pwm_cmp_level(mode, cnt_down);
                    else if (mode_q == OCM_TIMING || res.raw != raw_q)
                        ref_d = pwm_lvl;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q  <= 1'b0;
            raw_q  <= 1'b0;
            mode_q <= OCM_TIMING;
        end else begin
            ref_q  <= ref_d;
            raw_q  <= res.raw;
            mode_q <= mode;
        end
    end

    assign ref_o = ref_q;

    a_r4_force_low: assert property (@(posedge clk) disable iff (rst)
        (out_mode && mode == OCM_LOW) |=> !ref_o);
    a_r4_force_high: assert property (@(posedge clk) disable iff (rst)
        (out_mode && mode == OCM_HIGH) |=> ref_o);
    a_r3_toggle: assert property (@(posedge clk) disable iff (rst)
        (out_mode && mode == OCM_TOG && cnt_val == cmp_val) |=> (ref_o != $past(ref_o)));
    a_r11_hold_input_role: assert property (@(posedge clk) disable iff (rst)
        !out_mode |=> $stable(ref_o));
    a_r2_timing_hold: assert property (@(posedge clk) disable iff (rst)
        (mode == OCM_TIMING) |=> $stable(ref_o));

endmodule

// File: rtl/oc_channel.sv
module oc_channel
    import oc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_down,
    input  logic             upd_evt,
    input  logic             trig_edge,
    input  logic             ch_en,
    input  logic [2:0]       oc_mode,
    input  logic             shadow_en,
    input  logic             fast_en,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             sel_wr,
    input  logic [1:0]       sel_wdata,
    output logic             oc_ref,
    output logic [CNT_W-1:0] cmp_active,
    output logic [1:0]       io_sel
);
    io_sel_e  sel;
    oc_mode_e mode;

    assign mode = oc_mode_e'(oc_mode);

    oc_cmp_store #(.CNT_W(CNT_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .shadow_en (shadow_en),
        .upd_evt   (upd_evt),
        .wr        (cmp_wr),
        .wdata     (cmp_wdata),
        .active    (cmp_active)
    );

    oc_sel_lock u_sel (
        .clk   (clk),
        .rst   (rst),
        .ch_en (ch_en),
        .wr    (sel_wr),
        .wdata (io_sel_e'(sel_wdata)),
        .sel   (sel)
    );

    oc_ref_gen #(.CNT_W(CNT_W)) u_ref (
        .clk       (clk),
        .rst       (rst),
        .cnt_val   (cnt_val),
        .cnt_down  (cnt_down),
        .cmp_val   (cmp_active),
        .mode      (mode),
        .out_mode  (sel == IOS_OUT),
        .fast_en   (fast_en),
        .trig_edge (trig_edge),
        .ref_o     (oc_ref)
    );

    assign io_sel = sel;

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!oc_ref && cmp_active == '0 && io_sel == 2'b00));

endmodule

// File: tb/tb_oc_channel.sv
module tb_oc_channel;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] cnt_val = '0;
    logic cnt_down = 1'b0, upd_evt = 1'b0, trig_edge = 1'b0, ch_en = 1'b0;
    logic [2:0] oc_mode = 3'b000;
    logic shadow_en = 1'b0, fast_en = 1'b0, cmp_wr = 1'b0, sel_wr = 1'b0;
    logic [W-1:0] cmp_wdata = '0;
    logic [1:0] sel_wdata = 2'b00;
    logic oc_ref;
    logic [W-1:0] cmp_active;
    logic [1:0] io_sel;

    int checks = 0, failures = 0;
    string cur_req = "R1";

    // behavioural model state
    logic m_ref = 1'b0, m_raw = 1'b0;
    logic [W-1:0] m_act = '0, m_hold = '0;
    logic [1:0] m_sel = 2'b00;
    logic [2:0] m_prev_mode = 3'b000;

    always #10 clk = !clk;

    oc_channel #(.CNT_W(W)) dut (.*);

    task automatic model_step();
        logic raw, nref;
        logic [W-1:0] nact, nhold;
        if (rst) begin
            m_ref = 0; m_raw = 0; m_act = '0; m_hold = '0; m_sel = 0; m_prev_mode = 0;
            return;
        end
        raw  = cnt_down ? !(cnt_val > m_act) : (cnt_val < m_act);
        nref = m_ref;
        if (m_sel == 2'b00) begin
            case (oc_mode)
                3'b001: if (cnt_val == m_act) nref = 1;
                3'b010: if (cnt_val == m_act) nref = 0;
                3'b011: if (cnt_val == m_act) nref = !m_ref;
                3'b100: nref = 0;
                3'b101: nref = 1;
                3'b110, 3'b111: begin
                    if (fast_en && trig_edge)
                        nref = (oc_mode == 3'b111) ? !cnt_down : cnt_down;
                    else if (m_prev_mode == 3'b000 || raw != m_raw)
                        nref = (oc_mode == 3'b111) ? !raw : raw;
                end
                default: ;
            endcase
        end
        nact = m_act; nhold = m_hold;
        if (shadow_en && upd_evt) nact = m_hold;
        if (cmp_wr) begin
            nhold = cmp_wdata;
            if (!shadow_en) nact = cmp_wdata;
        end
        if (sel_wr && !ch_en) m_sel = sel_wdata;
        m_ref = nref; m_act = nact; m_hold = nhold; m_raw = raw; m_prev_mode = oc_mode;
    endtask

    task automatic check_bit(string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b", cur_req, what, act, exp);
        end
    endtask

    task automatic check_val(string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
        end
    endtask

    // one rising edge, then model update and comparison at the falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        model_step();
        check_bit("oc_ref", oc_ref, m_ref);
        check_val("cmp_active", cmp_active, m_act);
        check_val("io_sel", {14'd0, io_sel}, {14'd0, m_sel});
        cmp_wr = 0; sel_wr = 0; upd_evt = 0; trig_edge = 0;
    endtask

    task automatic write_cmp(logic [W-1:0] v);
        cmp_wr = 1; cmp_wdata = v; tick();
    endtask

    task automatic sweep(int lo, int hi, logic down);
        cnt_down = down;
        if (!down) for (int i = lo; i <= hi; i++) begin cnt_val = W'(i); tick(); end
        else       for (int i = hi; i >= lo; i--) begin cnt_val = W'(i); tick(); end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        cur_req = "R1";
        tick(); tick();
        check_bit("reset oc_ref", oc_ref, 1'b0);
        check_val("reset cmp_active", cmp_active, '0);
        rst = 0;

        cur_req = "R10";
        write_cmp(16'd5);
        check_val("direct write", cmp_active, 16'd5);
        upd_evt = 1; tick();
        check_val("upd ignored", cmp_active, 16'd5);

        cur_req = "R2";
        oc_mode = 3'b001; sweep(0, 8, 0);
        check_bit("set on match", oc_ref, 1'b1);
        oc_mode = 3'b000; sweep(0, 8, 0);
        oc_mode = 3'b010; sweep(0, 8, 0);
        check_bit("clear on match", oc_ref, 1'b0);

        cur_req = "R3";
        oc_mode = 3'b011; sweep(0, 10, 0); sweep(0, 10, 1); sweep(3, 7, 0);
        check_bit("three toggles", oc_ref, 1'b1);

        cur_req = "R4";
        oc_mode = 3'b100; sweep(0, 6, 0);
        check_bit("force low", oc_ref, 1'b0);
        oc_mode = 3'b101; sweep(0, 6, 0);
        check_bit("force high", oc_ref, 1'b1);

        cur_req = "R12";
        oc_mode = 3'b100; cnt_val = 0;
        @(posedge clk); #1;
        check_bit("one edge latency", oc_ref, 1'b0);
        @(negedge clk); model_step();

        cur_req = "R5";
        oc_mode = 3'b000; tick();
        oc_mode = 3'b110; sweep(0, 9, 0); sweep(0, 9, 1);
        cnt_val = 5; cnt_down = 1; tick();
        check_bit("pwm0 down at compare", oc_ref, 1'b1);

        cur_req = "R6";
        oc_mode = 3'b000; tick();
        oc_mode = 3'b111; sweep(0, 9, 0); sweep(0, 9, 1);
        cnt_val = 2; cnt_down = 0; tick(); tick();
        check_bit("pwm1 up below compare", oc_ref, 1'b0);

        cur_req = "R7";
        oc_mode = 3'b101; cnt_val = 8; cnt_down = 0; tick();
        oc_mode = 3'b110; tick(); tick(); tick();
        check_bit("no change on steady result", oc_ref, 1'b1);
        cnt_val = 3; tick(); tick();
        cnt_val = 9; tick();
        check_bit("change on result flip", oc_ref, 1'b0);

        cur_req = "R8";
        oc_mode = 3'b000; tick();
        oc_mode = 3'b111; fast_en = 1; cnt_val = 2; tick(); tick();
        trig_edge = 1; tick();
        check_bit("fast to compare level", oc_ref, 1'b1);
        tick(); tick();
        cnt_down = 1; cnt_val = 9; tick();
        trig_edge = 1; tick();
        check_bit("fast level down", oc_ref, 1'b0);
        fast_en = 0; oc_mode = 3'b110; cnt_down = 0; cnt_val = 9; tick();
        trig_edge = 1; tick(); tick();
        sweep(0, 9, 0);

        cur_req = "R9";
        shadow_en = 1; oc_mode = 3'b011;
        write_cmp(16'd9); tick(); tick();
        check_val("preload held", cmp_active, 16'd5);
        upd_evt = 1; tick();
        check_val("loaded on update", cmp_active, 16'd9);
        cmp_wr = 1; cmp_wdata = 16'd4; upd_evt = 1; tick();
        check_val("old holding value", cmp_active, 16'd9);
        upd_evt = 1; tick();
        check_val("new holding value", cmp_active, 16'd4);
        sweep(0, 10, 0);
        shadow_en = 0;

        cur_req = "R11";
        ch_en = 1; sel_wr = 1; sel_wdata = 2'b01; tick();
        check_val("locked write", {14'd0, io_sel}, 16'd0);
        ch_en = 0; sel_wr = 1; sel_wdata = 2'b10; tick();
        check_val("unlocked write", {14'd0, io_sel}, 16'd2);
        oc_mode = 3'b101; tick();
        oc_mode = 3'b100; tick(); sweep(0, 6, 0);
        oc_mode = 3'b101; tick();
        sel_wr = 1; sel_wdata = 2'b00; tick(); tick();
        check_bit("output role resumes", oc_ref, 1'b1);

        cur_req = "R1";
        rst = 1; tick();
        check_bit("re-reset oc_ref", oc_ref, 1'b0);
        check_val("re-reset cmp_active", cmp_active, '0);
        rst = 0; tick();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule